// File: doc/BRIEF.md
# Page-Mode DRAM Controller with Open-Row Miss Detection

This block drives one bank of asynchronous DRAM for a requester that issues single-word reads and writes. It keeps the last-used row open after every access by leaving the row strobe low. When the next request targets the same row it is served as a short column-only cycle. When it targets a different row, the row strobe is raised for the precharge time and the new row is opened.

The requester places a row, a column and a direction on the inputs and holds its request high. The ready output stays low until the word has been read or written. Ready then pulses high for exactly one clock, which tells the requester to drop its request. The hit/miss decision is made one clock after a request is accepted, against a registered copy of the open row that carries a valid bit.

All timing counts are parameters measured in controller clocks. The defaults fit a 30 ns clock: 3 clocks of row-strobe low time, 2 clocks of precharge, 1 clock from row to column, and 2 clocks of column strobe.

Top module: `page_dram_ctrl`

## Requirements
- R1: During and after reset, with no request pending, `ras_n_o`, `cas_n_o` and `we_n_o` are high, `rdy_o` is low, and no row is marked open.
- R2: The first access after reset needs no precharge. Number the clocks after the accepting edge as 0, 1, 2 and so on. `ras_n_o` is high only in clock 0 (the compare clock) and falls in clock RCD_CLKS-ish order: clock 1 carries the row. `rdy_o` is high in clock RCD_CLKS+CAS_CLKS.
- R3: After any access completes, `ras_n_o` stays low and `cas_n_o` stays high while no request is pending, so the row remains open.
- R4: A request to the open row (page hit) keeps `ras_n_o` low throughout. `rdy_o` is high in clock CAS_CLKS after the accepting edge.
- R5: A request to a different row (page miss) keeps `ras_n_o` low in the compare clock. It then holds `ras_n_o` high for exactly RP_CLKS clocks before reopening, and `rdy_o` is high in clock RP_CLKS+RCD_CLKS+CAS_CLKS.
- R6: Every low period of `ras_n_o` lasts at least RAS_MIN_CLKS clocks. Every high period that precedes a fall, except the one after reset, lasts at least RP_CLKS clocks.
- R7: In the clock where `ras_n_o` falls, `ma_o` equals the requested row (zero-extended). While `cas_n_o` is low, `ma_o` equals the requested column (zero-extended) and is stable.
- R8: `we_n_o` is low in every clock where `cas_n_o` is low for a write (`we_i`=1). It is high at all other times, including throughout reads.
- R9: `rdy_o` is high for exactly one clock per access, in the last clock where `cas_n_o` is low, and is low at all other times.
- R10: `cas_n_o` is low for exactly CAS_CLKS consecutive clocks per access and only while `ras_n_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Request, held high until `rdy_o` pulses |
| we_i | input | 1 | 1 = write, 0 = read |
| row_i | input | ROW_W | Row address of the request |
| col_i | input | COL_W | Column address of the request |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | DRAM write enable, active low |
| ma_o | output | MA_W | Multiplexed row/column address |
| rdy_o | output | 1 | One-clock completion pulse |

## Verification
The bench builds the block with a 3-bit row and a 2-bit column and keeps the default timing counts. This makes the row space small enough to run every ordered pair of rows back to back, so every hit and every miss transition from every open row is covered. Column and direction are derived arithmetically from the pair index, and the idle gap between requests varies from zero upward. This covers reads, writes, back-to-back requests and the first access after reset. For each access, the expected latency, precharge length and strobe widths are computed from the timing counts.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_OPEN,
      ST_CMP,
      ST_PRE,
      ST_ACT,
      ST_CAS
   } pdc_state_e;

   function automatic int pdc_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/pdc_timer.sv
module pdc_timer #(
   parameter int MAX_CNT = 4,
   localparam int CW = (MAX_CNT < 2) ? 1 : $clog2(MAX_CNT + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          zero
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                cnt_q <= '0;
      else if (load)             cnt_q <= load_val;
      else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

   a_r6_timer_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt_q <= CW'(MAX_CNT)));

endmodule

// File: rtl/pdc_row_tracker.sv
module pdc_row_tracker #(
   parameter int ROW_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             open_en,
   input  logic [ROW_W-1:0] req_row,
   output logic             open_vld,
   output logic             hit
);

   logic [ROW_W-1:0] open_row_q;
   logic             vld_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q      <= 1'b0;
         open_row_q <= '0;
      end else if (open_en) begin
         vld_q      <= 1'b1;
         open_row_q <= req_row;
      end
   end

   assign open_vld = vld_q;
   assign hit      = vld_q && (open_row_q == req_row);

   a_r3_row_stays_open: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q |=> vld_q);

   a_r3_opened_row_kept: assert property (@(posedge clk) disable iff (!rst_n)
      open_en |=> (open_row_q == $past(req_row)));

endmodule

// File: rtl/pdc_seq.sv
module pdc_seq
   import pdc_pkg::*;
#(
   parameter int RP_CLKS  = 2,
   parameter int RCD_CLKS = 1,
   parameter int CAS_CLKS = 2,
   localparam int MAXC = pdc_max(pdc_max(RP_CLKS, RCD_CLKS), CAS_CLKS),
   localparam int CW   = (MAXC < 2) ? 1 : $clog2(MAXC + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req,
   input  logic          open_vld,
   input  logic          hit,
   input  logic          cnt_zero,
   output logic          accept,
   output logic          cnt_load,
   output logic [CW-1:0] cnt_val,
   output logic          open_en,
   output logic          ras_n,
   output logic          cas_n,
   output logic          col_phase,
   output logic          done
);

   pdc_state_e st_q, st_d;

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   always_comb begin
      st_d     = st_q;
      cnt_load = 1'b0;
      cnt_val  = '0;
      accept   = 1'b0;
      unique case (st_q)
         ST_IDLE, ST_OPEN: begin
            if (req) begin
               accept = 1'b1;
               st_d   = ST_CMP;
            end
         end
         ST_CMP: begin
            cnt_load = 1'b1;
            if (hit) begin
               st_d    = ST_CAS;
               cnt_val = CW'(CAS_CLKS - 1);
            end else if (open_vld) begin
               st_d    = ST_PRE;
               cnt_val = CW'(RP_CLKS - 1);
            end else begin
               st_d    = ST_ACT;
               cnt_val = CW'(RCD_CLKS - 1);
            end
         end
         ST_PRE: begin
            if (cnt_zero) begin
               st_d     = ST_ACT;
               cnt_load = 1'b1;
               cnt_val  = CW'(RCD_CLKS - 1);
            end
         end
         ST_ACT: begin
            if (cnt_zero) begin
               st_d     = ST_CAS;
               cnt_load = 1'b1;
               cnt_val  = CW'(CAS_CLKS - 1);
            end
         end
         ST_CAS: begin
            if (cnt_zero) st_d = ST_OPEN;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   assign open_en   = (st_q == ST_ACT);
   assign col_phase = (st_q == ST_CAS);
   assign cas_n     = (st_q != ST_CAS);
   assign done      = (st_q == ST_CAS) && cnt_zero;
   assign ras_n     = (st_q == ST_IDLE) || (st_q == ST_PRE) ||
                      ((st_q == ST_CMP) && !open_vld);

   a_r4_hit_no_precharge: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_CMP && hit) |=> (!ras_n && !cas_n));

   a_r5_miss_precharges: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_CMP && open_vld && !hit) |-> (!ras_n ##1 ras_n));

   a_r2_first_opens_direct: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_CMP && !open_vld) |=> (!ras_n && cas_n));

   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r9_done_in_cas: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !cas_n);

   a_r3_open_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_OPEN) |-> (!ras_n && cas_n));

endmodule

// File: rtl/page_dram_ctrl.sv
module page_dram_ctrl
   import pdc_pkg::*;
#(
   parameter int ROW_W        = 10,
   parameter int COL_W        = 10,
   parameter int RAS_MIN_CLKS = 3,
   parameter int RP_CLKS      = 2,
   parameter int RCD_CLKS     = 1,
   parameter int CAS_CLKS     = 2,
   localparam int MA_W        = pdc_max(ROW_W, COL_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_i,
   input  logic             we_i,
   input  logic [ROW_W-1:0] row_i,
   input  logic [COL_W-1:0] col_i,
   output logic             ras_n_o,
   output logic             cas_n_o,
   output logic             we_n_o,
   output logic [MA_W-1:0]  ma_o,
   output logic             rdy_o
);

   localparam int MAXC = pdc_max(pdc_max(RP_CLKS, RCD_CLKS), CAS_CLKS);
   localparam int CW   = (MAXC < 2) ? 1 : $clog2(MAXC + 1);
   localparam int LW   = $clog2(RAS_MIN_CLKS + 2);
   localparam int HW   = $clog2(RP_CLKS + 2);

   if (ROW_W < 1 || COL_W < 1) begin : g_bad_width
      $error("page_dram_ctrl: address widths must be at least 1");
   end
   if (RP_CLKS < 1 || RCD_CLKS < 1 || CAS_CLKS < 1) begin : g_bad_count
      $error("page_dram_ctrl: timing counts must be at least 1");
   end
   if (RCD_CLKS + CAS_CLKS < RAS_MIN_CLKS) begin : g_bad_ras
      $error("page_dram_ctrl: row-to-column plus column time must cover row-low minimum");
   end

   logic             accept, cnt_load, cnt_zero, open_en, open_vld, hit;
   logic             ras_n, cas_n, col_phase, done;
   logic [CW-1:0]    cnt_val;
   logic [ROW_W-1:0] row_q;
   logic [COL_W-1:0] col_q;
   logic             we_q;
   logic [MA_W-1:0]  row_ext, col_ext;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         row_q <= '0;
         col_q <= '0;
         we_q  <= 1'b0;
      end else if (accept) begin
         row_q <= row_i;
         col_q <= col_i;
         we_q  <= we_i;
      end
   end

   if (ROW_W == MA_W) begin : g_row_full
      assign row_ext = row_q;
   end else begin : g_row_pad
      assign row_ext = {{(MA_W - ROW_W){1'b0}}, row_q};
   end

   if (COL_W == MA_W) begin : g_col_full
      assign col_ext = col_q;
   end else begin : g_col_pad
      assign col_ext = {{(MA_W - COL_W){1'b0}}, col_q};
   end

   pdc_seq #(
      .RP_CLKS  (RP_CLKS),
      .RCD_CLKS (RCD_CLKS),
      .CAS_CLKS (CAS_CLKS)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (req_i),
      .open_vld  (open_vld),
      .hit       (hit),
      .cnt_zero  (cnt_zero),
      .accept    (accept),
      .cnt_load  (cnt_load),
      .cnt_val   (cnt_val),
      .open_en   (open_en),
      .ras_n     (ras_n),
      .cas_n     (cas_n),
      .col_phase (col_phase),
      .done      (done)
   );

   pdc_timer #(
      .MAX_CNT (MAXC)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cnt_load),
      .load_val (cnt_val),
      .zero     (cnt_zero)
   );

   pdc_row_tracker #(
      .ROW_W (ROW_W)
   ) u_rows (
      .clk      (clk),
      .rst_n    (rst_n),
      .open_en  (open_en),
      .req_row  (row_q),
      .open_vld (open_vld),
      .hit      (hit)
   );

   assign ras_n_o = ras_n;
   assign cas_n_o = cas_n;
   assign we_n_o  = !(col_phase && we_q);
   assign ma_o    = col_phase ? col_ext : row_ext;
   assign rdy_o   = done;

   // Strobe-width watch counters for the timing properties below.
   logic [LW-1:0] lo_run_q;
   logic [HW-1:0] hi_run_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_run_q <= '0;
         hi_run_q <= HW'(RP_CLKS);
      end else begin
         if (ras_n_o)                         lo_run_q <= '0;
         else if (lo_run_q != LW'(RAS_MIN_CLKS)) lo_run_q <= lo_run_q + 1'b1;
         if (!ras_n_o)                        hi_run_q <= '0;
         else if (hi_run_q != HW'(RP_CLKS))   hi_run_q <= hi_run_q + 1'b1;
      end
   end

   a_r6_ras_low_min: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ras_n_o) |-> (lo_run_q >= LW'(RAS_MIN_CLKS)));

   a_r6_precharge_min: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n_o) |-> (hi_run_q >= HW'(RP_CLKS)));

   a_r10_cas_under_ras: assert property (@(posedge clk) disable iff (!rst_n)
      !cas_n_o |-> !ras_n_o);

   a_r7_col_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!cas_n_o && $past(!cas_n_o)) |-> $stable(ma_o));

   a_r8_we_only_in_cas: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n_o |-> !cas_n_o);

   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |=> (ras_n_o && cas_n_o && we_n_o && !rdy_o));

endmodule

// File: tb/page_dram_ctrl_tb.sv
module page_dram_ctrl_tb;

   localparam int ROW_W = 3;
   localparam int COL_W = 2;
   localparam int MA_W  = 3;
   localparam int RASM  = 3;
   localparam int RP    = 2;
   localparam int RCD   = 1;
   localparam int CASC  = 2;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             req = 1'b0;
   logic             we = 1'b0;
   logic [ROW_W-1:0] row = '0;
   logic [COL_W-1:0] col = '0;
   logic             ras_n, cas_n, we_n, rdy;
   logic [MA_W-1:0]  ma;

   int total = 0;
   int bad   = 0;
   bit open_vld = 1'b0;
   int open_row = 0;

   always #2.5 clk = ~clk;

   page_dram_ctrl #(
      .ROW_W (ROW_W), .COL_W (COL_W), .RAS_MIN_CLKS (RASM),
      .RP_CLKS (RP), .RCD_CLKS (RCD), .CAS_CLKS (CASC)
   ) u_dut (
      .clk (clk), .rst_n (rst_n), .req_i (req), .we_i (we),
      .row_i (row), .col_i (col), .ras_n_o (ras_n), .cas_n_o (cas_n),
      .we_n_o (we_n), .ma_o (ma), .rdy_o (rdy)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic access(input int r, input int c, input bit w, input int gap);
      int  idx, hi_cnt, cas_cnt, exp_lat, exp_hi;
      bit  prev_ras, fall_ok, col_ok, we_ok, fell;
      for (int g = 0; g < gap; g++) begin
         @(negedge clk);
         check(!ras_n == open_vld && cas_n && !rdy, "R3 idle row held", ras_n, !open_vld);
      end
      if (!open_vld) begin exp_lat = RCD + CASC;      exp_hi = 1;  end
      else if (open_row == r) begin exp_lat = CASC;   exp_hi = 0;  end
      else begin exp_lat = RP + RCD + CASC;           exp_hi = RP; end
      req = 1'b1; row = r[ROW_W-1:0]; col = c[COL_W-1:0]; we = w;
      prev_ras = ras_n;
      idx = -1; hi_cnt = 0; cas_cnt = 0;
      fall_ok = 1'b1; col_ok = 1'b1; we_ok = 1'b1; fell = 1'b0;
      do begin
         @(negedge clk);
         idx++;
         if (ras_n) hi_cnt++;
         if (prev_ras && !ras_n) begin
            fell = 1'b1;
            if (ma != MA_W'(r)) fall_ok = 1'b0;
         end
         if (!cas_n) begin
            cas_cnt++;
            if (ma != MA_W'(c) || ras_n) col_ok = 1'b0;
            if (we_n != !w) we_ok = 1'b0;
         end else if (!we_n) we_ok = 1'b0;
         prev_ras = ras_n;
      end while (!rdy && idx < 40);
      req = 1'b0;
      if (!open_vld)         check(idx == exp_lat, "R2 first latency", idx, exp_lat);
      else if (open_row == r) check(idx == exp_lat, "R4 hit latency", idx, exp_lat);
      else                   check(idx == exp_lat, "R5 miss latency", idx, exp_lat);
      if (open_row == r && open_vld) check(hi_cnt == 0, "R4 ras held low", hi_cnt, 0);
      else check(hi_cnt == exp_hi, "R5 R2 precharge length", hi_cnt, exp_hi);
      check(fell == (exp_hi != 0), "R6 row reopen", fell, exp_hi != 0);
      check(fall_ok, "R7 row on ras fall", ma, r);
      check(col_ok, "R7 column during cas", ma, c);
      check(we_ok, "R8 write enable", we_n, !w);
      check(cas_cnt == CASC, "R10 cas width", cas_cnt, CASC);
      open_vld = 1'b1;
      open_row = r;
      @(negedge clk);
      check(!ras_n && cas_n && !rdy && we_n, "R9 R3 after done", rdy, 0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      check(ras_n && cas_n && we_n && !rdy, "R1 in reset", ras_n, 1);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(ras_n && cas_n && we_n && !rdy, "R1 after reset", {ras_n, cas_n, we_n, rdy}, 4'b1110);
      access(5, 1, 1'b0, 0);
      for (int a = 0; a < (1 << ROW_W); a++) begin
         for (int b = 0; b < (1 << ROW_W); b++) begin
            access(a, (a + b) % (1 << COL_W), ((a ^ b) & 1) != 0, a % 3);
            access(b, (a * 3 + b) % (1 << COL_W), ((a + b) & 1) == 0, b % 2);
         end
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule